// File: doc/BRIEF.md
# Sixteen-Bit Timer Counter with Compare Clear

This block is a 16-bit up-counter that advances by one on each count-enable tick from an external prescaler. It keeps two 16-bit compare words, A and B. When the count first equals compare A, it raises a one-clock match pulse. If clear-on-compare is enabled and PWM mode is off, it also returns the counter to zero on the next CPU clock. The clear is timed by the CPU clock, not by the next tick. With slow ticks, the matched value is therefore visible for only one CPU clock, and zero fills the rest of that tick period.

Software reaches the block over an 8-bit bus. All 16-bit words share one 8-bit staging byte, so a full 16-bit access behaves as a single transfer:
- **Reads:** reading a low byte captures the matching high byte into the staging byte.
- **Writes:** writing a high byte fills the staging byte, and writing a low byte then loads the whole word in one clock.

A two-state machine watches for equality with compare A:
- **CMP_ARMED:** the count differed from compare A on the previous clock.
- **CMP_HELD:** the count equalled compare A on the previous clock.

Transitions:
- **ARMED to HELD:** on equality. This transition is the match event.
- **HELD to ARMED:** on inequality.
- **Staying put:** ARMED stays ARMED while the values differ, and HELD stays HELD while they are equal.

Reset enters HELD, so the zero-equals-zero state after reset does not produce an event.

Top module: `tc16_cmpclr`

## Requirements
- R1: After reset the counter, both compare words and the staging byte are zero, and the match output is low.
- R2: Each clock with the tick high increments the counter by one, and 0xFFFF wraps to 0x0000.
- R3: With clear-on-compare enabled and PWM mode off, the counter becomes 0x0000 on the clock after it first equals compare A. With a tick on every clock and compare value C, successive counts are C-2, C-1, C, 0, 1.
- R4: With one tick every 8 clocks and clear enabled, C is visible for a single clock and 0x0000 for the following 7 clocks. The counter then shows 1.
- R5: With clear-on-compare disabled, or with PWM mode set, a match leaves the count untouched and counting continues.
- R6: The match output is a one-clock pulse on the clock after the count first equals compare A. It does not repeat while the two stay equal.
- R7: Address map:
  - Addresses 0/1: count low/high.
  - Addresses 2/3: compare A low/high.
  - Addresses 4/5: compare B low/high.

  A low-byte read returns that word's low byte and copies its high byte into the staging byte. A high-byte read returns the staging byte. Addresses 6 and 7, and any clock without a read strobe, return 0x00.
- R8: A high-byte write places the data in the staging byte. A low-byte write loads {staging byte, data} into the addressed word at the next clock edge.
- R9: A bus write of the counter wins over a tick and over a compare clear in the same clock.
- R10: The staging byte is shared by all words: a high byte staged through one word's address is committed by a low-byte write to another word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable from the prescaler |
| clr_on_cmp | input | 1 | Enable zeroing after a compare-A match |
| pwm_mode | input | 1 | PWM mode flag; disables the compare clear |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Byte read strobe |
| addr | input | 3 | Byte address (see R7) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from addr and rd_en |
| cmp_match | output | 1 | One-clock compare-A match pulse |

## Verification
Three updates can fall on the counter in the same clock: a bus load, a compare clear and a tick. The bench provokes each pairing on purpose:
- **Load with tick:** it writes the counter low byte while the tick is high.
- **Load with clear:** it writes the counter low byte in the clock where the clear is pending.
- **Clear with tick:** it drives ticks every clock through the matched value.

Each outcome is judged against a behavioural model that applies load over clear over tick. The model also replays the staging byte, so a low-byte read that latches in the same clock as a tick is compared byte for byte.

// File: rtl/tc16_pkg.sv
`timescale 1ns/1ps
package tc16_pkg;
    typedef enum logic {
        CMP_ARMED = 1'b0,
        CMP_HELD  = 1'b1
    } cmp_state_t;

    localparam int SEL_COUNT = 0;
endpackage

// File: rtl/tc16_count_core.sv
`timescale 1ns/1ps
module tc16_count_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt_q
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // priority: bus load, then compare clear, then tick
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (clr)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= cnt_q + ONE;
    end

    // R9
    load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt_q == $past(load_val));
    // R2
    tick_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && !clr) |=> cnt_q == $past(cnt_q) + ONE);
    // R3
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !load) |=> cnt_q == '0);
endmodule

// File: rtl/tc16_cmp_unit.sv
`timescale 1ns/1ps
module tc16_cmp_unit
    import tc16_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_q,
    input  logic [CNT_W-1:0] cmpa,
    input  logic             clr_on_cmp,
    input  logic             pwm_mode,
    output logic             clr_req,
    output logic             cmp_match
);
    cmp_state_t state_q, state_d;
    logic       eq;
    logic       hit_evt;

    assign eq      = (cnt_q == cmpa);
    assign hit_evt = (state_q == CMP_ARMED) && eq;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CMP_ARMED: state_d = eq ? CMP_HELD : CMP_ARMED;
            CMP_HELD:  state_d = eq ? CMP_HELD : CMP_ARMED;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CMP_HELD;
        else        state_q <= state_d;
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) cmp_match <= 1'b0;
        else        cmp_match <= hit_evt;
    end

    assign clr_req = hit_evt && clr_on_cmp && !pwm_mode;

    // R6
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_match |=> !cmp_match);
endmodule

// File: rtl/tc16_bus_regs.sv
`timescale 1ns/1ps
module tc16_bus_regs
    import tc16_pkg::*;
#(
    parameter int BYTE_W  = 8,
    parameter int NUM_CMP = 2,
    parameter int ADDR_W  = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic                          rd_en,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [BYTE_W-1:0]             wdata,
    input  logic [2*BYTE_W-1:0]           cnt_q,
    output logic [BYTE_W-1:0]             rdata,
    output logic                          cnt_load,
    output logic [2*BYTE_W-1:0]           load_word,
    output logic [NUM_CMP*2*BYTE_W-1:0]   cmp_flat
);
    localparam int WORD_W  = 2 * BYTE_W;
    localparam int NUM_SEL = NUM_CMP + 1;
    localparam int SEL_W   = ADDR_W - 1;

    logic              hi_sel;
    logic [SEL_W-1:0]  sel;
    logic              sel_ok;
    logic [BYTE_W-1:0] temp_q;
    logic [WORD_W-1:0] src_word;

    assign hi_sel    = addr[0];
    assign sel       = addr[ADDR_W-1:1];
    assign sel_ok    = (int'(sel) < NUM_SEL);
    assign load_word = {temp_q, wdata};
    assign cnt_load  = wr_en && !hi_sel && (int'(sel) == SEL_COUNT);

    always_comb begin
        src_word = cnt_q;
        for (int k = 0; k < NUM_CMP; k++)
            if (int'(sel) == k + 1) src_word = cmp_flat[k*WORD_W +: WORD_W];
    end

    generate
        for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
            logic [WORD_W-1:0] word_q;
            always_ff @(posedge clk) begin
                if (!rst_n)
                    word_q <= '0;
                else if (wr_en && !hi_sel && int'(sel) == g + 1)
                    word_q <= load_word;
            end
            assign cmp_flat[g*WORD_W +: WORD_W] = word_q;
        end
    endgenerate

    // shared staging byte
    always_ff @(posedge clk) begin
        if (!rst_n)
            temp_q <= '0;
        else if (wr_en && hi_sel && sel_ok)
            temp_q <= wdata;
        else if (rd_en && !hi_sel && sel_ok)
            temp_q <= src_word[WORD_W-1:BYTE_W];
    end

    always_comb begin
        rdata = '0;
        if (rd_en && sel_ok)
            rdata = hi_sel ? temp_q : src_word[BYTE_W-1:0];
    end

    // R7
    low_read_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && !hi_sel && sel_ok) |=> temp_q == $past(src_word[WORD_W-1:BYTE_W]));
endmodule

// File: rtl/tc16_cmpclr.sv
`timescale 1ns/1ps
module tc16_cmpclr #(
    parameter int BYTE_W  = 8,
    parameter int NUM_CMP = 2,
    parameter int ADDR_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              clr_on_cmp,
    input  logic              pwm_mode,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    output logic              cmp_match
);
    localparam int WORD_W = 2 * BYTE_W;

    logic [WORD_W-1:0]         cnt_q;
    logic [WORD_W-1:0]         load_word;
    logic                      cnt_load;
    logic                      clr_req;
    logic [NUM_CMP*WORD_W-1:0] cmp_flat;
    logic [WORD_W-1:0]         cmpa;

    assign cmpa = cmp_flat[WORD_W-1:0];

    tc16_bus_regs #(.BYTE_W(BYTE_W), .NUM_CMP(NUM_CMP), .ADDR_W(ADDR_W)) u_bus (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .cnt_q(cnt_q), .rdata(rdata), .cnt_load(cnt_load),
        .load_word(load_word), .cmp_flat(cmp_flat)
    );

    tc16_cmp_unit #(.CNT_W(WORD_W)) u_cmp (
        .clk(clk), .rst_n(rst_n), .cnt_q(cnt_q), .cmpa(cmpa),
        .clr_on_cmp(clr_on_cmp), .pwm_mode(pwm_mode),
        .clr_req(clr_req), .cmp_match(cmp_match)
    );

    tc16_count_core #(.CNT_W(WORD_W)) u_core (
        .clk(clk), .rst_n(rst_n), .tick(tick), .load(cnt_load),
        .load_val(load_word), .clr(clr_req), .cnt_q(cnt_q)
    );

    // R5
    pwm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_mode && !cnt_load && !tick) |=> cnt_q == $past(cnt_q));
    // R6
    match_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_match |-> $past(cnt_q == cmpa));
endmodule

// File: tb/sim_tc16_cmpclr.sv
`timescale 1ns/1ps
module sim_tc16_cmpclr;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0, clr_on_cmp = 1'b0, pwm_mode = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       cmp_match;

    int  total = 0, bad = 0;
    bit  done = 0, live = 0;

    always #2.5 clk = ~clk;

    tc16_cmpclr u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .clr_on_cmp(clr_on_cmp),
        .pwm_mode(pwm_mode), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .cmp_match(cmp_match)
    );

    // behavioural reference
    logic [15:0] m_cnt, m_cmpa, m_cmpb;
    logic [7:0]  m_tmp;
    bit          m_prev_eq, m_match;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_cmpa = 0; m_cmpb = 0; m_tmp = 0; m_prev_eq = 1; m_match = 0;
        end else begin
            automatic bit          eq  = (m_cnt == m_cmpa);
            automatic bit          evt = eq && !m_prev_eq;
            automatic logic [15:0] n_cnt = m_cnt;
            automatic logic [7:0]  n_tmp = m_tmp;
            if (tick) n_cnt = m_cnt + 16'd1;
            if (evt && clr_on_cmp && !pwm_mode) n_cnt = 0;
            if (wr_en && addr == 0) n_cnt = {m_tmp, wdata};
            if (wr_en && (addr == 1 || addr == 3 || addr == 5)) n_tmp = wdata;
            else if (rd_en && addr == 0) n_tmp = m_cnt[15:8];
            else if (rd_en && addr == 2) n_tmp = m_cmpa[15:8];
            else if (rd_en && addr == 4) n_tmp = m_cmpb[15:8];
            if (wr_en && addr == 2) m_cmpa = {m_tmp, wdata};
            if (wr_en && addr == 4) m_cmpb = {m_tmp, wdata};
            m_cnt = n_cnt; m_tmp = n_tmp; m_prev_eq = eq; m_match = evt;
        end
    end

    function automatic logic [7:0] model_rd();
        if (!rd_en) return 8'h00;
        case (addr)
            3'd0: return m_cnt[7:0];
            3'd2: return m_cmpa[7:0];
            3'd4: return m_cmpb[7:0];
            3'd1, 3'd3, 3'd5: return m_tmp;
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (live) begin
            chk(rdata == model_rd(), "R7 model rdata", rdata, model_rd());
            chk(cmp_match == m_match, "R6 model match", cmp_match, m_match);
        end
    end

    task automatic nxt(); @(posedge clk); #1; endtask

    task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1; nxt(); wr_en = 0;
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [7:0] exp, input string tag);
        addr = a; rd_en = 1;
        @(negedge clk);
        chk(rdata == exp, tag, rdata, exp);
        nxt(); rd_en = 0;
    endtask

    task automatic load_cnt(input logic [15:0] v);
        bus_wr(3'd1, v[15:8]); bus_wr(3'd0, v[7:0]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] seq3 [5];
        int n10, n00, pulses;
        repeat (3) @(posedge clk);
        #1 rst_n = 1; live = 1;

        // R1 reset state
        @(negedge clk);
        chk(cmp_match == 0, "R1 match after reset", cmp_match, 0);
        nxt();
        for (int a = 0; a < 6; a++) rd_chk(3'(a), 8'h00, "R1 reset value");

        // R8 compare A commit, R7 read back
        bus_wr(3'd3, 8'h00); bus_wr(3'd2, 8'h10);
        rd_chk(3'd2, 8'h10, "R8 cmpA low");
        rd_chk(3'd3, 8'h00, "R7 cmpA high via staging");
        load_cnt(16'h1234);
        rd_chk(3'd0, 8'h34, "R8 count low");
        rd_chk(3'd1, 8'h12, "R7 count high via staging");

        // R10 staging shared across words
        bus_wr(3'd1, 8'hAB); bus_wr(3'd4, 8'hCD);
        rd_chk(3'd4, 8'hCD, "R10 cmpB low");
        rd_chk(3'd5, 8'hAB, "R10 cmpB high");
        rd_chk(3'd6, 8'h00, "R7 unmapped read");

        // R2 wrap
        load_cnt(16'hFFFE);
        tick = 1; nxt(); nxt(); tick = 0;
        rd_chk(3'd0, 8'h00, "R2 wrap low");
        rd_chk(3'd1, 8'h00, "R2 wrap high");

        // R3 clear with tick every clock, R6 pulse timing
        clr_on_cmp = 1;
        load_cnt(16'h000E);
        seq3 = '{8'h0E, 8'h0F, 8'h10, 8'h00, 8'h01};
        for (int i = 0; i < 5; i++) begin
            tick = 1; rd_en = 1; addr = 3'd0;
            @(negedge clk);
            chk(rdata == seq3[i], "R3 count sequence", rdata, seq3[i]);
            chk(cmp_match == (i == 3), "R6 pulse timing", cmp_match, (i == 3));
            nxt();
        end
        tick = 0; rd_en = 0;

        // R4 tick every 8 clocks
        load_cnt(16'h000F);
        n10 = 0; n00 = 0;
        for (int i = 0; i < 16; i++) begin
            tick = (i % 8 == 0); rd_en = 1; addr = 3'd0;
            @(negedge clk);
            if (rdata == 8'h10) n10++;
            if (rdata == 8'h00) n00++;
            nxt();
        end
        tick = 0; rd_en = 0;
        chk(n10 == 1, "R4 clocks at C", n10, 1);
        chk(n00 == 7, "R4 clocks at zero", n00, 7);

        // R5 clear disabled, then PWM mode
        for (int pass = 0; pass < 2; pass++) begin
            clr_on_cmp = (pass == 1); pwm_mode = (pass == 1);
            load_cnt(16'h000F);
            for (int i = 0; i < 4; i++) begin
                tick = 1; rd_en = 1; addr = 3'd0;
                @(negedge clk);
                chk(rdata == 8'(8'h0F + i), "R5 no clear", rdata, 8'h0F + i);
                nxt();
            end
            tick = 0; rd_en = 0;
        end
        pwm_mode = 0; clr_on_cmp = 0;

        // R6 no repeat while held equal
        load_cnt(16'h000F);
        pulses = 0;
        for (int i = 0; i < 10; i++) begin
            tick = (i == 0);
            @(negedge clk);
            if (cmp_match) pulses++;
            nxt();
        end
        tick = 0;
        chk(pulses == 1, "R6 single pulse", pulses, 1);

        // R9 load vs tick, load vs clear
        clr_on_cmp = 1;
        bus_wr(3'd1, 8'h01);
        addr = 3'd0; wdata = 8'h00; wr_en = 1; tick = 1; nxt(); wr_en = 0; tick = 0;
        rd_chk(3'd0, 8'h00, "R9 load over tick low");
        rd_chk(3'd1, 8'h01, "R9 load over tick high");
        load_cnt(16'h000F);
        tick = 1; nxt(); tick = 0;
        addr = 3'd0; wdata = 8'h55; wr_en = 1; nxt(); wr_en = 0;
        rd_chk(3'd0, 8'h55, "R9 load over clear");

        nxt();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule